// File: doc/BRIEF.md
# ADC Global Configuration Register with Touch-Drive Decoder

This block holds the global configuration word of an ADC front end behind a synchronous CPU read/write port. It turns the stored fields into control outputs: a converter clock enable with its power-down complement, the input-source select, and the positive and negative channel selects for the analog multiplexer. It also drives two-bit states for the four touchscreen plate lines and enables a pen-down detector. The converter, the multiplexer and the pad drivers sit outside this block. They reach it only through these outputs and through the `conv_done` and `pen_in` inputs.

The clock-enable field also acts as a guard for the rest of the ADC register window. While it is clear, writes to every address in that window are blocked, except this register and one auxiliary configuration register, and each blocked write raises a one-cycle error strobe. Clearing the enable produces a one-cycle flush pulse that resets the conversion sequencer and discards pending triggers. Setting the enable starts a settle timer; a ready flag asserts when that timer has run out. A wake-up output merges conversion completion with the gated pen-down status.

Top module: `adcfg_ctrl`

## Requirements
- R1: After reset the stored word is zero. A read returns 0x0000, `adc_clk_en`=0, `adc_pwrdn`=1 and `adc_ready`=0, and all four line drives are 0 (inactive).
- R2: The field layout is bit 0 enable, bit 1 source, bit 2 differential, bits 5:3 channel, bits 8:6 touch mode. A read strobe to `CFG_ADDR` returns these fields as written on `cpu_rdata` one cycle later. Bits 14:9 read 0, and bit 15 reads the pen-down status.
- R3: `adc_clk_en` follows bit 0 from the cycle after the write, and `adc_pwrdn` is always its inverse.
- R4: While the enable is 0, a write to a window address other than `CFG_ADDR` and `AUX_ADDR` leaves `oth_we` low and pulses `lock_err` in the next cycle. Writes to `AUX_ADDR`, and any window write while enabled, raise `oth_we` in the same cycle.
- R5: A write that changes the enable from 1 to 0 raises `seq_flush` for exactly one cycle, in the first cycle in which `adc_clk_en` is 0. Writing 0 when the enable is already 0 gives no pulse.
- R6: `adc_ready` rises exactly `READY_CYC` cycles after `adc_clk_en` rises. It is 0 whenever `adc_clk_en` is 0.
- R7: `ext_sel` equals bit 1: 0 selects the eight-way multiplexer and 1 selects the dedicated input pin.
- R8: In single-ended mode (bit 2 = 0), `ch_pos` equals the channel field, `neg_en`=0 and `ch_neg`=0.
- R9: In differential mode, `ch_pos` equals channel n, `ch_neg` equals n XOR 1, and `neg_en`=1.
- R10: Line drives are encoded 0 inactive, 1 driven high, 2 driven low, 3 weak pull-up. The touch modes decode as follows:
  - 000 none: all lines inactive.
  - 001 pre-pen-down: X− and Y− low.
  - 010 sample X: X+ high and X− low.
  - 011 sample Y: Y+ high and Y− low.
  - 100 sample Z (both Z samples): Y+ high and X− low.
  - 101 pen detect: X+ pull-up and Y− low.
  - 110 and 111 are reserved: all lines inactive.
- R11: `pen_det_en` is 1 only for touch mode 101. The pen status is `pen_in` AND `pen_det_en`.
- R12: `wake` is the OR of `conv_done` and the pen status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | CPU write strobe |
| cpu_re | input | 1 | CPU read strobe |
| cpu_addr | input | ADDR_W | CPU address |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_rdata | output | DATA_W | Registered read data |
| oth_we | output | 1 | Gated write strobe for the other window registers |
| lock_err | output | 1 | One-cycle strobe for a blocked write |
| adc_clk_en | output | 1 | Converter clock enable |
| adc_pwrdn | output | 1 | Analog power-down |
| adc_ready | output | 1 | Converter settled |
| seq_flush | output | 1 | Sequencer reset and trigger discard pulse |
| ext_sel | output | 1 | Input source select |
| ch_pos | output | 3 | Positive channel select |
| ch_neg | output | 3 | Negative channel select |
| neg_en | output | 1 | Negative input in use |
| drv_xp | output | 2 | X+ line drive |
| drv_yp | output | 2 | Y+ line drive |
| drv_xn | output | 2 | X− line drive |
| drv_yn | output | 2 | Y− line drive |
| pen_det_en | output | 1 | Pen-down detector enable |
| pen_in | input | 1 | Pen-down detector output |
| conv_done | input | 1 | Conversion done |
| wake | output | 1 | Wake-up request |

## Verification
Two wake sources can be active in the same cycle: the conversion-done input and the gated pen-down status. The bench drives each source alone, then both together, then neither, and expects `wake` high in the first three cases and low in the last. It also raises the pen input with the touch mode set away from 101, where it must have no effect on `wake`. A second coincidence occurs when the enable is cleared: the flush pulse, the loss of ready and the onset of the write lock all take effect on the same edge. A locked write issued right after the clear must be refused and flagged.

// File: rtl/adcfg_pkg.sv
package adcfg_pkg;
  typedef enum logic [1:0] {
    DRV_OFF = 2'd0,
    DRV_HI  = 2'd1,
    DRV_LO  = 2'd2,
    DRV_PU  = 2'd3
  } drv_e;

  localparam int CH_W  = 3;
  localparam int TCH_W = 3;

  typedef struct packed {
    logic [TCH_W-1:0] touch;
    logic [CH_W-1:0]  chan;
    logic             diff;
    logic             ext;
    logic             en;
  } cfg_t;

  localparam int CFG_BITS = $bits(cfg_t);

  typedef struct packed {
    drv_e xp;
    drv_e yp;
    drv_e xn;
    drv_e yn;
  } line_drv_t;

  localparam logic [TCH_W-1:0] TCH_NONE = 3'b000;
  localparam logic [TCH_W-1:0] TCH_PRE  = 3'b001;
  localparam logic [TCH_W-1:0] TCH_X    = 3'b010;
  localparam logic [TCH_W-1:0] TCH_Y    = 3'b011;
  localparam logic [TCH_W-1:0] TCH_Z    = 3'b100;
  localparam logic [TCH_W-1:0] TCH_PEN  = 3'b101;
endpackage

// File: rtl/adcfg_wgate.sv
module adcfg_wgate #(
  parameter int ADDR_W   = 8,
  parameter int WIN_BASE = 64,
  parameter int WIN_SIZE = 8,
  parameter int CFG_ADDR = 64,
  parameter int AUX_ADDR = 65
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic              cpu_re,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              clk_en,
  output logic              cfg_we,
  output logic              cfg_re,
  output logic              oth_we,
  output logic              lock_err
);
  localparam logic [ADDR_W:0]   WIN_LO = (ADDR_W+1)'(WIN_BASE);
  localparam logic [ADDR_W:0]   WIN_HI = (ADDR_W+1)'(WIN_BASE + WIN_SIZE);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(CFG_ADDR);
  localparam logic [ADDR_W-1:0] A_AUX  = ADDR_W'(AUX_ADDR);

  logic in_win, is_cfg, is_aux, blocked;
  logic lock_d, lock_q;

  always_comb begin
    in_win  = ({1'b0, cpu_addr} >= WIN_LO) && ({1'b0, cpu_addr} < WIN_HI);
    is_cfg  = (cpu_addr == A_CFG);
    is_aux  = (cpu_addr == A_AUX);
    blocked = cpu_we && in_win && !is_cfg && !is_aux && !clk_en;
    cfg_we  = cpu_we && is_cfg;
    cfg_re  = cpu_re && is_cfg;
    oth_we  = cpu_we && in_win && !is_cfg && !blocked;
    lock_d  = blocked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b0;
    else        lock_q <= lock_d;
  end

  assign lock_err = lock_q;
endmodule

// File: rtl/adcfg_reg.sv
module adcfg_reg
  import adcfg_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_re,
  input  logic [CFG_BITS-1:0] wdata,
  input  logic              pen_stat,
  output cfg_t              cfg,
  output logic [DATA_W-1:0] rdata,
  output logic              flush
);
  cfg_t              cfg_d, cfg_q;
  logic [DATA_W-1:0] rdata_d, rdata_q;
  logic              flush_d, flush_q;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we) cfg_d = cfg_t'(wdata);
    flush_d = cfg_q.en && !cfg_d.en;
    rdata_d = '0;
    if (cfg_re) begin
      rdata_d[CFG_BITS-1:0] = cfg_q;
      rdata_d[DATA_W-1]     = pen_stat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      rdata_q <= '0;
      flush_q <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      rdata_q <= rdata_d;
      flush_q <= flush_d;
    end
  end

  assign cfg   = cfg_q;
  assign rdata = rdata_q;
  assign flush = flush_q;
endmodule

// File: rtl/adcfg_touch_dec.sv
module adcfg_touch_dec
  import adcfg_pkg::*;
(
  input  logic [TCH_W-1:0] mode,
  output line_drv_t        drv,
  output logic             pen_en
);
  always_comb begin
    drv    = '{xp: DRV_OFF, yp: DRV_OFF, xn: DRV_OFF, yn: DRV_OFF};
    pen_en = 1'b0;
    case (mode)
      TCH_PRE: begin
        drv.xn = DRV_LO;
        drv.yn = DRV_LO;
      end
      TCH_X: begin
        drv.xp = DRV_HI;
        drv.xn = DRV_LO;
      end
      TCH_Y: begin
        drv.yp = DRV_HI;
        drv.yn = DRV_LO;
      end
      TCH_Z: begin
        drv.yp = DRV_HI;
        drv.xn = DRV_LO;
      end
      TCH_PEN: begin
        drv.xp = DRV_PU;
        drv.yn = DRV_LO;
        pen_en = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/adcfg_ready_tmr.sv
module adcfg_ready_tmr #(
  parameter int READY_CYC = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic ready
);
  localparam int CW = $clog2(READY_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(READY_CYC);

  logic [CW-1:0] cnt_d, cnt_q;
  logic          cnt_ce;

  always_comb begin
    cnt_ce = en && (cnt_q != LIMIT);
    cnt_d  = cnt_q;
    if (!en)        cnt_d = '0;
    else if (cnt_ce) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign ready = en && (cnt_q == LIMIT);
endmodule

// File: rtl/adcfg_ctrl.sv
module adcfg_ctrl
  import adcfg_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int WIN_BASE  = 64,
  parameter int WIN_SIZE  = 8,
  parameter int CFG_ADDR  = 64,
  parameter int AUX_ADDR  = 65,
  parameter int READY_CYC = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic              cpu_re,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              oth_we,
  output logic              lock_err,
  output logic              adc_clk_en,
  output logic              adc_pwrdn,
  output logic              adc_ready,
  output logic              seq_flush,
  output logic              ext_sel,
  output logic [2:0]        ch_pos,
  output logic [2:0]        ch_neg,
  output logic              neg_en,
  output logic [1:0]        drv_xp,
  output logic [1:0]        drv_yp,
  output logic [1:0]        drv_xn,
  output logic [1:0]        drv_yn,
  output logic              pen_det_en,
  input  logic              pen_in,
  input  logic              conv_done,
  output logic              wake
);
  cfg_t      cfg;
  line_drv_t drv;
  logic      cfg_we, cfg_re, pen_en, pen_stat;

  adcfg_wgate #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE),
    .CFG_ADDR(CFG_ADDR), .AUX_ADDR(AUX_ADDR)
  ) u_wgate (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_re(cpu_re),
    .cpu_addr(cpu_addr), .clk_en(cfg.en), .cfg_we(cfg_we),
    .cfg_re(cfg_re), .oth_we(oth_we), .lock_err(lock_err)
  );

  adcfg_reg #(.DATA_W(DATA_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_re(cfg_re),
    .wdata(cpu_wdata[CFG_BITS-1:0]), .pen_stat(pen_stat),
    .cfg(cfg), .rdata(cpu_rdata), .flush(seq_flush)
  );

  adcfg_touch_dec u_touch (.mode(cfg.touch), .drv(drv), .pen_en(pen_en));

  adcfg_ready_tmr #(.READY_CYC(READY_CYC)) u_rdy (
    .clk(clk), .rst_n(rst_n), .en(cfg.en), .ready(adc_ready)
  );

  always_comb begin
    adc_clk_en = cfg.en;
    adc_pwrdn  = !cfg.en;
    ext_sel    = cfg.ext;
    neg_en     = cfg.diff;
    ch_pos     = cfg.chan;
    ch_neg     = cfg.diff ? (cfg.chan ^ 3'd1) : 3'd0;
    drv_xp     = drv.xp;
    drv_yp     = drv.yp;
    drv_xn     = drv.xn;
    drv_yn     = drv.yn;
    pen_det_en = pen_en;
    pen_stat   = pen_in && pen_en;
    wake       = conv_done || pen_stat;
  end
endmodule

// File: rtl/adcfg_ctrl_chk.sv
module adcfg_ctrl_chk #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int WIN_BASE = 64,
  parameter int WIN_SIZE = 8,
  parameter int CFG_ADDR = 64,
  parameter int AUX_ADDR = 65
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_we,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              oth_we,
  input logic              lock_err,
  input logic              adc_clk_en,
  input logic              adc_pwrdn,
  input logic              adc_ready,
  input logic              seq_flush,
  input logic [2:0]        ch_pos,
  input logic [2:0]        ch_neg,
  input logic              neg_en,
  input logic [1:0]        drv_xp,
  input logic [1:0]        drv_yp,
  input logic [1:0]        drv_xn,
  input logic [1:0]        drv_yn,
  input logic              pen_det_en,
  input logic              conv_done,
  input logic              wake
);
  logic locked_wr;
  always_comb
    locked_wr = cpu_we && !adc_clk_en
             && (int'(cpu_addr) >= WIN_BASE) && (int'(cpu_addr) < WIN_BASE + WIN_SIZE)
             && (int'(cpu_addr) != CFG_ADDR) && (int'(cpu_addr) != AUX_ADDR);

  AST_LOCK_BLOCK: assert property (@(posedge clk) disable iff (!rst_n) locked_wr |-> !oth_we); // R4
  AST_LOCK_FLAG:  assert property (@(posedge clk) disable iff (!rst_n) locked_wr |=> lock_err); // R4
  AST_FLUSH_FALL: assert property (@(posedge clk) disable iff (!rst_n) $fell(adc_clk_en) |-> seq_flush); // R5
  AST_FLUSH_ONE:  assert property (@(posedge clk) disable iff (!rst_n) seq_flush |=> !seq_flush); // R5
  AST_FLUSH_OFF:  assert property (@(posedge clk) disable iff (!rst_n) seq_flush |-> !adc_clk_en); // R5
  AST_READY_OFF:  assert property (@(posedge clk) disable iff (!rst_n) !adc_clk_en |-> !adc_ready); // R6
  AST_PWRDN_INV:  assert property (@(posedge clk) disable iff (!rst_n) adc_pwrdn != adc_clk_en); // R3
  AST_DIFF_PAIR:  assert property (@(posedge clk) disable iff (!rst_n) neg_en |-> (ch_neg == (ch_pos ^ 3'd1))); // R9
  AST_PEN_DRIVE:  assert property (@(posedge clk) disable iff (!rst_n)
                    pen_det_en |-> (drv_xp == 2'd3 && drv_yn == 2'd2 && drv_yp == 2'd0 && drv_xn == 2'd0)); // R10
  AST_WAKE_DONE:  assert property (@(posedge clk) disable iff (!rst_n) conv_done |-> wake); // R12
  AST_RSV_ZERO:   assert property (@(posedge clk) disable iff (!rst_n) cpu_rdata[DATA_W-2:9] == '0); // R2
endmodule

bind adcfg_ctrl adcfg_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_BASE(WIN_BASE),
  .WIN_SIZE(WIN_SIZE), .CFG_ADDR(CFG_ADDR), .AUX_ADDR(AUX_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
  .cpu_rdata(cpu_rdata), .oth_we(oth_we), .lock_err(lock_err),
  .adc_clk_en(adc_clk_en), .adc_pwrdn(adc_pwrdn), .adc_ready(adc_ready),
  .seq_flush(seq_flush), .ch_pos(ch_pos), .ch_neg(ch_neg), .neg_en(neg_en),
  .drv_xp(drv_xp), .drv_yp(drv_yp), .drv_xn(drv_xn), .drv_yn(drv_yn),
  .pen_det_en(pen_det_en), .conv_done(conv_done), .wake(wake)
);

// File: tb/tb_adcfg_ctrl.sv
`timescale 1ns/1ps
module tb_adcfg_ctrl;
  localparam int RDY = 6;
  localparam logic [7:0] A_CFG = 8'h40;
  localparam logic [7:0] A_AUX = 8'h41;
  localparam logic [7:0] A_OTH = 8'h43;

  logic clk = 1'b0;
  logic rst_n;
  logic cpu_we, cpu_re, pen_in, conv_done;
  logic [7:0]  cpu_addr;
  logic [15:0] cpu_wdata, cpu_rdata;
  logic oth_we, lock_err, adc_clk_en, adc_pwrdn, adc_ready, seq_flush, ext_sel;
  logic neg_en, pen_det_en, wake;
  logic [2:0] ch_pos, ch_neg;
  logic [1:0] drv_xp, drv_yp, drv_xn, drv_yn;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] exp_q[$];
  logic rd_pend;
  logic we_seen;

  always #2.5 clk = ~clk;

  adcfg_ctrl #(.READY_CYC(RDY)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_re(cpu_re),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .oth_we(oth_we), .lock_err(lock_err), .adc_clk_en(adc_clk_en),
    .adc_pwrdn(adc_pwrdn), .adc_ready(adc_ready), .seq_flush(seq_flush),
    .ext_sel(ext_sel), .ch_pos(ch_pos), .ch_neg(ch_neg), .neg_en(neg_en),
    .drv_xp(drv_xp), .drv_yp(drv_yp), .drv_xn(drv_xn), .drv_yn(drv_yn),
    .pen_det_en(pen_det_en), .pen_in(pen_in), .conv_done(conv_done), .wake(wake)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Drive a write; we_seen captures the combinational gated strobe
  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    #1 we_seen = oth_we;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  // Read of the config register: expected word goes to the scoreboard
  task automatic rd(input logic [15:0] exp);
    @(negedge clk);
    cpu_re = 1'b1; cpu_addr = A_CFG;
    exp_q.push_back(exp);
    @(negedge clk);
    cpu_re = 1'b0;
  endtask

  always @(posedge clk or negedge rst_n)
    if (!rst_n) rd_pend <= 1'b0;
    else        rd_pend <= cpu_re && (cpu_addr == A_CFG);

  always @(negedge clk) begin
    if (rd_pend) begin
      if (exp_q.size() == 0) chk("R2 unexpected read", 32'(cpu_rdata), 32'hFFFF_FFFF);
      else chk("R2 read data", 32'(cpu_rdata), 32'(exp_q.pop_front()));
    end
  end

  function automatic logic [7:0] exp_drv(input logic [2:0] t);
    case (t)
      3'd1: return 8'b00_00_10_10;
      3'd2: return 8'b01_00_10_00;
      3'd3: return 8'b00_01_00_10;
      3'd4: return 8'b00_01_10_00;
      3'd5: return 8'b11_00_00_10;
      default: return 8'b0;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cpu_we = 0; cpu_re = 0; cpu_addr = 0; cpu_wdata = 0;
    pen_in = 0; conv_done = 0; we_seen = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 clk_en", 32'(adc_clk_en), 0);
    chk("R1 pwrdn", 32'(adc_pwrdn), 1);
    chk("R1 ready", 32'(adc_ready), 0);
    chk("R1 drives", 32'({drv_xp, drv_yp, drv_xn, drv_yn}), 0);
    rd(16'h0000); // R1

    // R4 locked write while disabled
    wr(A_OTH, 16'h1234);
    chk("R4 locked oth_we", 32'(we_seen), 0);
    chk("R4 lock_err pulse", 32'(lock_err), 1);
    @(negedge clk);
    chk("R4 lock_err clears", 32'(lock_err), 0);
    wr(A_AUX, 16'h0001);
    chk("R4 aux oth_we", 32'(we_seen), 1);
    chk("R4 aux no lock_err", 32'(lock_err), 0);

    // R3 R7 R8 enable, ext source, single-ended chan 5
    wr(A_CFG, 16'h002B);
    chk("R3 clk_en", 32'(adc_clk_en), 1);
    chk("R3 pwrdn", 32'(adc_pwrdn), 0);
    chk("R7 ext_sel", 32'(ext_sel), 1);
    chk("R8 ch_pos", 32'(ch_pos), 5);
    chk("R8 neg_en", 32'(neg_en), 0);
    chk("R8 ch_neg", 32'(ch_neg), 0);
    // R6 ready timing
    chk("R6 ready at 0", 32'(adc_ready), 0);
    for (int i = 1; i < RDY; i++) begin
      @(negedge clk);
      chk("R6 ready early", 32'(adc_ready), 0);
    end
    @(negedge clk);
    chk("R6 ready on time", 32'(adc_ready), 1);
    rd(16'h002B); // R2
    wr(A_OTH, 16'h0055);
    chk("R4 enabled oth_we", 32'(we_seen), 1);
    chk("R4 enabled no lock_err", 32'(lock_err), 0);

    // R7 mux source select
    wr(A_CFG, 16'h0029);
    chk("R7 ext_sel low", 32'(ext_sel), 0);

    // R9 differential pairs
    for (int n = 0; n < 8; n++) begin
      wr(A_CFG, 16'(1 | 4 | (n << 3)));
      chk("R9 ch_pos", 32'(ch_pos), 32'(n));
      chk("R9 ch_neg", 32'(ch_neg), 32'(n ^ 1));
      chk("R9 neg_en", 32'(neg_en), 1);
    end

    // R10 R11 touch decode
    for (int t = 0; t < 8; t++) begin
      wr(A_CFG, 16'(1 | (t << 6)));
      chk("R10 drives", 32'({drv_xp, drv_yp, drv_xn, drv_yn}), 32'(exp_drv(3'(t))));
      chk("R11 pen_det_en", 32'(pen_det_en), 32'(t == 5));
    end

    // R11 R12 wake sources, alone and coincident
    wr(A_CFG, 16'h0141);
    @(negedge clk); pen_in = 1; conv_done = 0; #1;
    chk("R12 wake pen only", 32'(wake), 1);
    rd(16'h8141); // R11 status bit
    @(negedge clk); pen_in = 0; conv_done = 1; #1;
    chk("R12 wake done only", 32'(wake), 1);
    @(negedge clk); pen_in = 1; conv_done = 1; #1;
    chk("R12 wake both", 32'(wake), 1);
    @(negedge clk); pen_in = 0; conv_done = 0; #1;
    chk("R12 wake none", 32'(wake), 0);
    wr(A_CFG, 16'h0081);
    pen_in = 1; #1;
    chk("R11 pen ignored off mode", 32'(wake), 0);
    rd(16'h0081); // R11
    pen_in = 0;

    // R2 reserved bits read zero
    wr(A_CFG, 16'hFFFF);
    rd(16'h01FF);
    chk("R10 reserved mode drives", 32'({drv_xp, drv_yp, drv_xn, drv_yn}), 0);

    // R5 R6 disable: flush, ready drop, lock same edge
    wr(A_CFG, 16'h0000);
    chk("R5 flush pulse", 32'(seq_flush), 1);
    chk("R6 ready drops", 32'(adc_ready), 0);
    chk("R3 clk_en off", 32'(adc_clk_en), 0);
    wr(A_OTH, 16'h0001);
    chk("R5 flush one cycle", 32'(seq_flush), 0);
    chk("R4 lock after clear", 32'(we_seen), 0);
    chk("R4 lock_err after clear", 32'(lock_err), 1);
    wr(A_CFG, 16'h0000);
    chk("R5 no flush when already off", 32'(seq_flush), 0);

    repeat (3) @(negedge clk);
    chk("R2 scoreboard drained", 32'(exp_q.size()), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule